// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block connects two 18-bit buses, called side A and side B, and carries data across them in either direction. Each direction has its own storage word, and three controls select how that word behaves. The first is a latch-enable level. While it is high the path is transparent and the output follows the input. While it is low the output holds its value, except that a rising edge on the direction's own capture clock loads the current input. The third control is an output-enable that states whether the far-side driver is active. The A-to-B enable is active high and the B-to-A enable is active low.

The block runs on one fast system clock. Both capture-clock inputs are treated as asynchronous levels. Each is passed through a synchroniser, and its rising edges are found in the sampled stream. The tristate buses are modelled for synthesis as separate input, output and output-enable vectors, so pad logic outside the block combines them. Typical uses are a registered bridge between two bus segments, or a level latch that freezes a bus snapshot.

Top module: `bidir_latreg_xcvr`

## Requirements
- R1: While a direction's latch-enable is high, that direction's output equals its data input in the same cycle, bit for bit with no inversion.
- R2: While a direction's latch-enable stays low and no rising capture edge is detected, that direction's output does not change, whatever its data input does.
- R3: The capture clock is sampled by a two-stage synchroniser, and a rising edge is a 0 sample followed by a 1 sample. The stages clear to 0 in reset. With latch-enable low, the data input present when the edge is detected is loaded, and it appears on the output no later than the fourth system clock edge after the capture clock rises.
- R4: When latch-enable falls, the output keeps the last value seen while the path was transparent. This holds whether the capture clock is high or low at that moment.
- R5: `b_oe` equals `ab_oe_i` (active high) delayed by one system clock.
- R6: `a_oe` equals the inverse of `ba_oe_n_i` (active low) delayed by one system clock.
- R7: While `rst_n` is low at a clock edge, both storage words clear to zero and both output-enables go low.
- R8: The controls and data of one direction never affect the output or output-enable of the other direction.
- R9: A single rise of a capture clock yields a detected edge for one system cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Side A bus as received |
| b_in | input | 18 | Side B bus as received |
| ab_oe_i | input | 1 | Drive side B, active high |
| ab_le_i | input | 1 | A-to-B transparent when high |
| ab_clk_i | input | 1 | A-to-B capture clock, asynchronous |
| ba_oe_n_i | input | 1 | Drive side A, active low |
| ba_le_i | input | 1 | B-to-A transparent when high |
| ba_clk_i | input | 1 | B-to-A capture clock, asynchronous |
| b_out | output | 18 | Value to drive onto side B |
| b_oe | output | 1 | Side B driver enable |
| a_out | output | 18 | Value to drive onto side A |
| a_oe | output | 1 | Side A driver enable |

## Verification
The hardest case to reach is a held value that depends on the order in which the latch-enable and the capture clock changed. One example is latch-enable falling while the clock is already high, followed by a data change before the next rise. Another is a rise that arrives together with a latch-enable change. The stimulus sweeps a sequence in which each direction's latch-enable, clock level and enable are separate bit functions of a step counter, so every ordering of falls and rises turns up. A directed sequence then drops latch-enable with the clock high, changes the data, and lowers and raises the clock. A bench model keeps a held word and the last clock level for each direction.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
   typedef struct packed {
      logic le;   // transparent when high
      logic cp;   // capture clock level (asynchronous)
      logic en;   // raw output-enable level, polarity set per lane
   } bxr_ctl_t;
endpackage

// File: rtl/bxr_edge_sync.sv
module bxr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("bxr_edge_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise_o = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/bxr_lane.sv
module bxr_lane
   import bxr_pkg::*;
#(
   parameter int W             = 18,
   parameter int STAGES        = 2,
   parameter bit OE_ACTIVE_LOW = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  bxr_ctl_t     ctl,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         oe_o,
   output logic         rise_o
);
   logic [W-1:0] store_q;
   logic         en_lvl;
   logic         oe_q;

   if (W < 1) begin : g_bad_w
      $error("bxr_lane: W must be positive");
   end

   bxr_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ctl.cp),
      .rise_o  (rise_o)
   );

   // Storage tracks the input while transparent so a closing latch holds the last seen value.
   always_ff @(posedge clk) begin
      if (!rst_n)                 store_q <= '0;
      else if (ctl.le || rise_o)  store_q <= din;
   end

   assign dout = ctl.le ? din : store_q;

   if (OE_ACTIVE_LOW) begin : g_oe_low
      assign en_lvl = ~ctl.en;
   end else begin : g_oe_high
      assign en_lvl = ctl.en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= en_lvl;
   end

   assign oe_o = oe_q;
endmodule

// File: rtl/bidir_latreg_xcvr.sv
module bidir_latreg_xcvr
   import bxr_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              ab_oe_i,
   input  logic              ab_le_i,
   input  logic              ab_clk_i,
   input  logic              ba_oe_n_i,
   input  logic              ba_le_i,
   input  logic              ba_clk_i,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe
);
   bxr_ctl_t ab_ctl;
   bxr_ctl_t ba_ctl;
   logic     ab_rise;
   logic     ba_rise;

   assign ab_ctl = '{le: ab_le_i, cp: ab_clk_i, en: ab_oe_i};
   assign ba_ctl = '{le: ba_le_i, cp: ba_clk_i, en: ba_oe_n_i};

   bxr_lane #(.W(DATA_W), .STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b0)) u_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ab_ctl),
      .din    (a_in),
      .dout   (b_out),
      .oe_o   (b_oe),
      .rise_o (ab_rise)
   );

   bxr_lane #(.W(DATA_W), .STAGES(SYNC_STAGES), .OE_ACTIVE_LOW(1'b1)) u_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ba_ctl),
      .din    (b_in),
      .dout   (a_out),
      .oe_o   (a_oe),
      .rise_o (ba_rise)
   );
endmodule

// File: rtl/bidir_latreg_xcvr_chk.sv
module bidir_latreg_xcvr_chk #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] b_in,
   input logic              ab_oe_i,
   input logic              ab_le_i,
   input logic              ba_oe_n_i,
   input logic              ba_le_i,
   input logic [DATA_W-1:0] b_out,
   input logic              b_oe,
   input logic [DATA_W-1:0] a_out,
   input logic              a_oe,
   input logic              ab_rise,
   input logic              ba_rise
);
   AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ab_le_i && !ab_rise) && !ab_le_i) |-> $stable(b_out)); // R2
   AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ba_le_i && !ba_rise) && !ba_le_i) |-> $stable(a_out)); // R2
   AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ab_le_i && ab_rise) && !ab_le_i) |-> b_out == $past(a_in)); // R3
   AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ba_le_i && ba_rise) && !ba_le_i) |-> a_out == $past(b_in)); // R3
   AST_AB_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(ab_le_i)) |-> b_out == $past(a_in)); // R4
   AST_BA_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(ba_le_i)) |-> a_out == $past(b_in)); // R4
   AST_B_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> b_oe == $past(ab_oe_i)); // R5
   AST_A_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> a_oe == !$past(ba_oe_n_i)); // R6
   AST_RESET_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!b_oe && !a_oe)); // R7
   AST_AB_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> !(ab_rise && $past(ab_rise))); // R9
   AST_BA_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> !(ba_rise && $past(ba_rise))); // R9
endmodule

bind bidir_latreg_xcvr bidir_latreg_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .a_in      (a_in),
   .b_in      (b_in),
   .ab_oe_i   (ab_oe_i),
   .ab_le_i   (ab_le_i),
   .ba_oe_n_i (ba_oe_n_i),
   .ba_le_i   (ba_le_i),
   .b_out     (b_out),
   .b_oe      (b_oe),
   .a_out     (a_out),
   .a_oe      (a_oe),
   .ab_rise   (ab_rise),
   .ba_rise   (ba_rise)
);

// File: tb/bidir_latreg_xcvr_tb.sv
`timescale 1ns/1ps
module bidir_latreg_xcvr_tb;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         ab_oe_i = 1'b0, ab_le_i = 1'b0, ab_clk_i = 1'b0;
   logic         ba_oe_n_i = 1'b1, ba_le_i = 1'b0, ba_clk_i = 1'b0;
   logic [W-1:0] b_out, a_out;
   logic         b_oe, a_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model: held word and last clock level per direction
   logic [W-1:0] held_ab = '0, held_ba = '0;
   logic         lvl_ab = 1'b0, lvl_ba = 1'b0;

   always #4 clk = ~clk;

   bidir_latreg_xcvr #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_oe_i(ab_oe_i), .ab_le_i(ab_le_i), .ab_clk_i(ab_clk_i),
      .ba_oe_n_i(ba_oe_n_i), .ba_le_i(ba_le_i), .ba_clk_i(ba_clk_i),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
   );

   task automatic chk_word(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic wait_cycles(int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // drive both directions, update model, settle, check all four outputs
   task automatic step(string tag,
                       logic le1, logic cp1, logic oe1, logic [W-1:0] d1,
                       logic le2, logic cp2, logic oen2, logic [W-1:0] d2);
      ab_le_i = le1; ab_clk_i = cp1; ab_oe_i = oe1;  a_in = d1;
      ba_le_i = le2; ba_clk_i = cp2; ba_oe_n_i = oen2; b_in = d2;
      if (le1 || (cp1 && !lvl_ab)) held_ab = d1;
      if (le2 || (cp2 && !lvl_ba)) held_ba = d2;
      lvl_ab = cp1;
      lvl_ba = cp2;
      wait_cycles(6);
      chk_word({tag, " R1 R2 R3 R8 b_out"}, b_out, le1 ? d1 : held_ab);
      chk_word({tag, " R1 R2 R3 R8 a_out"}, a_out, le2 ? d2 : held_ba);
      chk_bit ({tag, " R5 b_oe"}, b_oe, oe1);
      chk_bit ({tag, " R6 a_oe"}, a_oe, ~oen2);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R7: enables asserted on inputs during reset must not reach outputs
      ab_oe_i = 1'b1; ba_oe_n_i = 1'b0;
      a_in = 18'h3FFFF; b_in = 18'h15555;
      wait_cycles(3);
      chk_bit ("R7 reset b_oe", b_oe, 1'b0);
      chk_bit ("R7 reset a_oe", a_oe, 1'b0);
      chk_word("R7 reset b_out", b_out, '0);
      chk_word("R7 reset a_out", a_out, '0);
      rst_n = 1'b1;
      wait_cycles(2);

      // sweep of orderings; each control a different bit function of s
      for (int s = 0; s < 128; s++) begin
         logic [6:0]   b;
         logic [W-1:0] da, db;
         b  = s[6:0];
         da = W'((s * 32'h0000B5A3) ^ 32'h2AAAA);
         db = W'((s * 32'h00007C4D) ^ 32'h1234F);
         step("sweep", b[0], b[1] ^ b[2], b[3], da,
                       b[2] ^ b[4], b[0] ^ b[5], b[1] ^ b[6], db);
      end

      // R4 R2 R3: latch closes with clock high, then data moves, then clock cycles
      step("R4 open clk high", 1'b1, 1'b1, 1'b1, 18'h0A5A5, 1'b1, 1'b1, 1'b0, 18'h1C3C3);
      step("R4 close clk high", 1'b0, 1'b1, 1'b1, 18'h31111, 1'b0, 1'b1, 1'b0, 18'h02222);
      step("R2 clk falls", 1'b0, 1'b0, 1'b1, 18'h2BEEF, 1'b0, 1'b0, 1'b0, 18'h0FACE);
      step("R3 clk rises", 1'b0, 1'b1, 1'b1, 18'h2BEEF, 1'b0, 1'b1, 1'b0, 18'h0FACE);
      step("R2 data moves", 1'b0, 1'b1, 1'b0, 18'h00001, 1'b0, 1'b1, 1'b1, 18'h20000);
      // R4: latch closes with clock low
      step("R4 open clk low", 1'b1, 1'b0, 1'b1, 18'h12345, 1'b1, 1'b0, 1'b0, 18'h2ABCD);
      step("R4 close clk low", 1'b0, 1'b0, 1'b1, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 18'h00000);
      // R8: one direction captures while the other holds
      step("R8 ab only", 1'b0, 1'b1, 1'b1, 18'h13579, 1'b0, 1'b0, 1'b0, 18'h02468);

      // R7: mid-run reset clears stores and enables
      rst_n = 1'b0;
      ab_le_i = 1'b0; ba_le_i = 1'b0; ab_clk_i = 1'b0; ba_clk_i = 1'b0;
      wait_cycles(2);
      chk_word("R7 midrun b_out", b_out, '0);
      chk_word("R7 midrun a_out", a_out, '0);
      chk_bit ("R7 midrun b_oe", b_oe, 1'b0);
      chk_bit ("R7 midrun a_oe", a_oe, 1'b0);
      rst_n = 1'b1;
      held_ab = '0; held_ba = '0; lvl_ab = 1'b0; lvl_ba = 1'b0;
      step("R7 after reset", 1'b0, 1'b0, 1'b0, 18'h3AAAA, 1'b0, 1'b0, 1'b1, 18'h05555);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule